// File: doc/BRIEF.md
# Two-Coin Vending Sequence Controller

This block is a Moore state machine that sells an item priced at two identical coins. A single level input reports that a coin is present in the acceptor. The machine answers each coin with an acceptance flag that stays high while the coin input stays high. After each coin is released, the machine walks through release and wait steps before it arms for the next coin. After the second coin is released, it raises a dispense flag, then starts over.

The coin level passes through a small synchronizer that runs on every clock. The state register moves only on clock cycles where the tick input is high. This lets the controller run on a fast system clock while its sequence advances at a slower tick rate. Both outputs are decoded from the state register alone. Reset is asynchronous and active low. It overrides the tick.

Top module: `coin_pair_vendor`

## Requirements
- R1: While rst_ni is low, coin_ack_o and vend_o are 0. Driving rst_ni low clears both outputs at once, without waiting for a clock edge, even in the middle of a sale.
- R2: After reset, and after each dispense, the machine passes unconditionally through an initial step into a wait step. The next coin then starts a fresh sale, so sales repeat without limit.
- R3: In a coin step, coin_ack_o is 1. It stays 1 for as long as coin_i stays high. A coin held high for any length of time counts as exactly one coin.
- R4: When a held coin is released, the machine passes through a release step and then a wait step before the next coin is armed. A coin that is asserted again after only one low clock is still accepted as the next coin.
- R5: vend_o rises only after the second accepted coin has been released, never after the first. During dispense, coin_ack_o is 0.
- R6: With tick_i held high, vend_o is high for exactly one clock per sale. With tick_i high one cycle in N, vend_o is high for N clocks.
- R7: With tick_i held high, coin_ack_o rises at the third rising clock edge after coin_i rises, and falls at the third rising edge after coin_i falls. A coin_i pulse lasting a single clock is still accepted as one coin.
- R8: While tick_i is low, the state does not advance. An inserted coin does not raise coin_ack_o until tick_i returns.
- R9: Reset takes priority over tick_i. With rst_ni low and tick_i high, the outputs stay 0. A coin held across the release of reset is accepted as the first coin of a new sale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock enable that advances the state register |
| coin_i | input | 1 | Debounced coin-present level, asynchronous to clk_i |
| coin_ack_o | output | 1 | High while a coin is being accepted |
| vend_o | output | 1 | High during the dispense step |

## Verification
The hardest case to reach from the ports is a coin that comes back while the machine is still in a release step. The stimulus drops coin_i for exactly one clock between two coins, so the synchronized level is low at only a single tick edge. A second hard case is a reset that arrives between clock edges in the middle of a sale. The stimulus lowers rst_ni a fraction of a period after a falling edge and samples the outputs before the next rising edge. Sparse ticks, a stopped tick, and a coin held across reset release are driven against a scoreboard of expected acceptance and dispense events.

// File: rtl/cpv_pkg.sv
package cpv_pkg;
  localparam int unsigned ST_COUNT = 8;

  localparam int unsigned I_INIT  = 0;
  localparam int unsigned I_WAIT1 = 1;
  localparam int unsigned I_COIN1 = 2;
  localparam int unsigned I_REL1  = 3;
  localparam int unsigned I_WAIT2 = 4;
  localparam int unsigned I_COIN2 = 5;
  localparam int unsigned I_REL2  = 6;
  localparam int unsigned I_VEND  = 7;

  typedef logic [ST_COUNT-1:0] st_vec_t;

  localparam st_vec_t ST_INIT  = st_vec_t'(1) << I_INIT;
  localparam st_vec_t ST_WAIT1 = st_vec_t'(1) << I_WAIT1;
  localparam st_vec_t ST_COIN1 = st_vec_t'(1) << I_COIN1;
  localparam st_vec_t ST_REL1  = st_vec_t'(1) << I_REL1;
  localparam st_vec_t ST_WAIT2 = st_vec_t'(1) << I_WAIT2;
  localparam st_vec_t ST_COIN2 = st_vec_t'(1) << I_COIN2;
  localparam st_vec_t ST_REL2  = st_vec_t'(1) << I_REL2;
  localparam st_vec_t ST_VEND  = st_vec_t'(1) << I_VEND;
endpackage

// File: rtl/cpv_sync.sv
module cpv_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
      end
    end
  endgenerate

  assign q_o = sh_q[LAST];
endmodule

// File: rtl/cpv_next.sv
module cpv_next
  import cpv_pkg::*;
(
  input  st_vec_t cur_i,
  input  logic    coin_i,
  output st_vec_t nxt_o
);
  always_comb begin
    case (cur_i)
      ST_INIT:  nxt_o = ST_WAIT1;
      ST_WAIT1: nxt_o = coin_i ? ST_COIN1 : ST_WAIT1;
      ST_COIN1: nxt_o = coin_i ? ST_COIN1 : ST_REL1;
      ST_REL1:  nxt_o = ST_WAIT2;
      ST_WAIT2: nxt_o = coin_i ? ST_COIN2 : ST_WAIT2;
      ST_COIN2: nxt_o = coin_i ? ST_COIN2 : ST_REL2;
      ST_REL2:  nxt_o = ST_VEND;
      ST_VEND:  nxt_o = ST_INIT;
      default:  nxt_o = ST_INIT;
    endcase
  end
endmodule

// File: rtl/cpv_outdec.sv
module cpv_outdec
  import cpv_pkg::*;
(
  input  st_vec_t cur_i,
  output logic    ack_o,
  output logic    vend_o
);
  always_comb begin
    ack_o  = cur_i[I_COIN1] | cur_i[I_COIN2];
    vend_o = cur_i[I_VEND];
  end
endmodule

// File: rtl/coin_pair_vendor.sv
module coin_pair_vendor #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic coin_i,
  output logic coin_ack_o,
  output logic vend_o
);
  import cpv_pkg::*;

  logic    coin_s;
  st_vec_t state_q;
  st_vec_t state_nxt;

  cpv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (coin_i),
    .q_o    (coin_s)
  );

  cpv_next u_next (
    .cur_i  (state_q),
    .coin_i (coin_s),
    .nxt_o  (state_nxt)
  );

  // Reset wins over the tick; the register holds between ticks.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= ST_INIT;
    else if (tick_i) state_q <= state_nxt;
  end

  cpv_outdec u_dec (
    .cur_i  (state_q),
    .ack_o  (coin_ack_o),
    .vend_o (vend_o)
  );

  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_q) == 1);

  a_r2_init_to_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q[I_INIT] && tick_i) |=> state_q[I_WAIT1]);

  a_r3_hold_coin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q[I_COIN1] && coin_s && tick_i) |=> state_q[I_COIN1]);

  a_r5_vend_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vend_o) |-> $past(state_q[I_REL2]));

  a_r2_vend_to_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q[I_VEND] && tick_i) |=> state_q[I_INIT]);

  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q));
endmodule

// File: tb/coin_pair_vendor_test.sv
module coin_pair_vendor_test;
  localparam int CLK_PERIOD = 10;
  localparam int EV_ACK  = 1;
  localparam int EV_VEND = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic coin_i = 1'b0;
  logic coin_ack_o;
  logic vend_o;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  int tick_cnt = 0;
  int coin_cnt = 0;
  int exp_vend_w = 1;
  bit done = 1'b0;
  int exp_q[$];

  coin_pair_vendor uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .coin_i     (coin_i),
    .coin_ack_o (coin_ack_o),
    .vend_o     (vend_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick_cnt <= tick_cnt + 1;
    tick_i <= (tick_div != 0) && ((tick_cnt % (tick_div == 0 ? 1 : tick_div)) == 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard model: every coin yields an ACK event, every second coin a VEND event.
  task automatic push_coin();
    exp_q.push_back(EV_ACK);
    coin_cnt++;
    if (coin_cnt == 2) begin
      exp_q.push_back(EV_VEND);
      coin_cnt = 0;
    end
  endtask

  task automatic insert_coin(input int hold, input int gap);
    @(negedge clk);
    coin_i = 1'b1;
    push_coin();
    repeat (hold) @(negedge clk);
    coin_i = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // Monitor: samples a quarter period after each rising edge.
  logic ack_prev = 1'b0;
  logic vend_prev = 1'b0;
  int   vend_run = 0;
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (coin_ack_o && !ack_prev) begin
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected ack", EV_ACK, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(e == EV_ACK, "R5 event order at ack", EV_ACK, e);
      end
    end
    if (vend_o && !vend_prev) begin
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected vend", EV_VEND, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(e == EV_VEND, "R5 event order at vend", EV_VEND, e);
      end
    end
    if (vend_o) begin
      vend_run++;
      check(!coin_ack_o, "R5 ack low during vend", int'(coin_ack_o), 0);
    end else if (vend_prev) begin
      check(vend_run == exp_vend_w, "R6 vend width", vend_run, exp_vend_w);
      vend_run = 0;
    end
    ack_prev = coin_ack_o;
    vend_prev = vend_o;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!coin_ack_o && !vend_o, "R1 outputs in reset", {coin_ack_o, vend_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check(!coin_ack_o && !vend_o, "R2 idle after reset", {coin_ack_o, vend_o}, 0);

    // R7 latency: ack rises at the third edge after coin rises.
    @(negedge clk);
    coin_i = 1'b1;
    push_coin();
    @(posedge clk); @(posedge clk); #(CLK_PERIOD/4);
    check(!coin_ack_o, "R7 ack not yet after two edges", int'(coin_ack_o), 0);
    @(posedge clk); #(CLK_PERIOD/4);
    check(coin_ack_o, "R7 ack after third edge", int'(coin_ack_o), 1);
    // R3 long hold keeps ack high.
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #(CLK_PERIOD/4);
      check(coin_ack_o, "R3 ack held while coin high", int'(coin_ack_o), 1);
    end
    @(negedge clk);
    coin_i = 1'b0;
    @(posedge clk); @(posedge clk); #(CLK_PERIOD/4);
    check(coin_ack_o, "R7 ack still high two edges after release", int'(coin_ack_o), 1);
    @(posedge clk); #(CLK_PERIOD/4);
    check(!coin_ack_o, "R7 ack falls third edge after release", int'(coin_ack_o), 0);
    check(!vend_o, "R5 no vend after first coin", int'(vend_o), 0);
    repeat (6) @(negedge clk);
    check(!vend_o, "R5 no vend while waiting for second coin", int'(vend_o), 0);
    insert_coin(5, 10);   // second coin: vend expected

    // R2 repeated sales with varied holds.
    insert_coin(3, 8);
    insert_coin(12, 8);
    insert_coin(1, 8);    // R7 single-clock coin pulse
    insert_coin(1, 8);

    // R4 coin comes back after one low clock, during the release step.
    @(negedge clk);
    coin_i = 1'b1; push_coin();
    repeat (6) @(negedge clk);
    coin_i = 1'b0;
    @(negedge clk);
    coin_i = 1'b1; push_coin();
    repeat (6) @(negedge clk);
    coin_i = 1'b0;
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R4 quick reinsert accepted", exp_q.size(), 0);

    // R8 stopped tick freezes the state.
    tick_div = 0;
    repeat (3) @(negedge clk);
    coin_i = 1'b1; push_coin();
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #(CLK_PERIOD/4);
      check(!coin_ack_o, "R8 no ack while tick low", int'(coin_ack_o), 0);
    end
    @(negedge clk);
    tick_div = 1;
    repeat (6) @(negedge clk);
    check(coin_ack_o, "R8 ack once tick resumes", int'(coin_ack_o), 1);
    coin_i = 1'b0;
    repeat (8) @(negedge clk);
    insert_coin(4, 10);

    // R6 sparse tick: vend lasts one tick period.
    tick_div = 3;
    exp_vend_w = 3;
    insert_coin(12, 16);
    insert_coin(12, 20);
    check(exp_q.size() == 0, "R6 sparse sale completed", exp_q.size(), 0);
    tick_div = 1;
    exp_vend_w = 1;
    repeat (4) @(negedge clk);

    // R1 asynchronous reset in mid-sale.
    @(negedge clk);
    coin_i = 1'b1; push_coin();
    repeat (6) @(negedge clk);
    check(coin_ack_o, "R1 ack high before async reset", int'(coin_ack_o), 1);
    #(CLK_PERIOD/8);
    rst_ni = 1'b0;
    #1;
    check(!coin_ack_o && !vend_o, "R1 outputs clear without edge", {coin_ack_o, vend_o}, 0);
    coin_cnt = 0;

    // R9 reset holds over tick, coin held across release.
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #(CLK_PERIOD/4);
      check(!coin_ack_o && !vend_o, "R9 reset beats tick", {coin_ack_o, vend_o}, 0);
    end
    @(negedge clk);
    push_coin();
    rst_ni = 1'b1;
    repeat (8) @(negedge clk);
    check(coin_ack_o, "R9 held coin accepted after reset", int'(coin_ack_o), 1);
    coin_i = 1'b0;
    repeat (8) @(negedge clk);
    insert_coin(2, 12);

    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule